// File: doc/BRIEF.md
# Address Window Persistence Classifier

This block gives every memory request one of three cache-policy classes. Software programs one window with a start address, a length in bytes and an 8-bit hit share. The window is cut into equal segments whose size is a power of two. Some segments are persisting and the rest are streaming. The number of persisting segments is about the hit share times the number of segments. An address outside the window gets the outside class, which means the normal cache policy.

Which segments persist is decided by a hash of the segment index mixed with a seed. The seed is captured when software commits the configuration, and the outcome does not depend on what was accessed before. Nothing in the block is stored per segment. The class is computed fresh for each request, so a segment keeps its class until the next commit. The cache places persisting data in its reserved region, gives streaming data a low priority, and uses its normal policy for outside data.

Top module: `pwin_classifier`

## Requirements
- R1: `rsp_valid` equals the value of `req_valid` one clock earlier, and `rsp_class` belongs to the request made in that same earlier cycle.
- R2: The class codes are 2'b00 for outside, 2'b01 for persisting and 2'b10 for streaming. The code 2'b11 never appears.
- R3: An address is in the window when `addr >= base` and `addr - base < len`, using ADDR_W-bit arithmetic. Any other address returns 2'b00. A length of zero makes every address outside.
- R4: The segment index is `(addr - base) >> SEG_SHIFT`. Every address in the same segment gets the same class.
- R5: Let idx be the low 16 bits of the segment index. Compute x = idx ^ seed, then y = x ^ (x >> 7), then z = (y * 16'h2F5B) mod 2^16. The hash is z[15:8]. A segment is persisting when the hash is less than the ratio, and streaming otherwise.
- R6: A ratio of 8'hFF makes every segment in the window persisting. A ratio of 8'h00 makes every segment streaming.
- R7: Raising `cfg_commit` captures base, length, ratio and seed together. A request made in the commit cycle uses the previous configuration. The next request uses the new one.
- R8: While no commit happens, repeated requests to one address always return the same class.
- R9: After reset the length is zero and the ratio and seed are zero. `rsp_valid` is 0 and `rsp_class` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | ADDR_W | Window start address to capture |
| cfg_len | input | ADDR_W | Window length in bytes to capture |
| cfg_ratio | input | 8 | Hit share, in units of 1/256 (8'hFF means all) |
| cfg_seed | input | 16 | Seed for the segment hash |
| cfg_commit | input | 1 | Captures all four configuration fields at once |
| req_valid | input | 1 | A request address is present |
| req_addr | input | ADDR_W | Request address |
| rsp_valid | output | 1 | Registered response valid |
| rsp_class | output | 2 | Registered class: 00 outside, 01 persisting, 10 streaming |

## Verification
The bench builds the block with a 32-bit address and 64-byte segments (SEG_SHIFT = 6). A 4 KiB window then holds 64 segments, so a hash sweep covers every segment in a few hundred cycles. With a full 32-bit address space, the bench can place a window against the top of memory and check that the low addresses do not wrap into it. The 64-byte segment size also lets the bench probe the first and last byte of each segment and compare the two classes.

// File: rtl/pwin_pkg.sv
package pwin_pkg;

  typedef enum logic [1:0] {
    CLS_OUT     = 2'b00,
    CLS_PERSIST = 2'b01,
    CLS_STREAM  = 2'b10
  } pwin_class_e;

  localparam int unsigned HASH_IDX_W = 16;
  localparam int unsigned HASH_W     = 8;

  // Segment hash: xor with the seed, a right xorshift, then an odd multiply.
  // The top byte of the product is the hash value.
  function automatic logic [HASH_W-1:0] pwin_hash(
    input logic [HASH_IDX_W-1:0] idx,
    input logic [HASH_IDX_W-1:0] seed
  );
    logic [HASH_IDX_W-1:0] x;
    logic [HASH_IDX_W-1:0] y;
    logic [HASH_IDX_W-1:0] z;
    x = idx ^ seed;
    y = x ^ (x >> 7);
    z = y * 16'h2F5B;
    return z[HASH_IDX_W-1 -: HASH_W];
  endfunction

endpackage

// File: rtl/pwin_cfg_regs.sv
module pwin_cfg_regs #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned RATIO_W = 8,
  parameter int unsigned SEED_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [SEED_W-1:0] seed_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] len_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [SEED_W-1:0] seed_o
);

  // One enable for all four fields keeps the update atomic (R7).
  always_ff @(posedge clk) begin
    if (rst) begin
      base_o  <= '0;
      len_o   <= '0;
      ratio_o <= '0;
      seed_o  <= '0;
    end else if (commit_i) begin
      base_o  <= base_i;
      len_o   <= len_i;
      ratio_o <= ratio_i;
      seed_o  <= seed_i;
    end
  end

  a_r7_commit_latch: assert property (@(posedge clk) disable iff (rst)
    commit_i |=> (base_o == $past(base_i) && len_o == $past(len_i) &&
                  ratio_o == $past(ratio_i) && seed_o == $past(seed_i)));

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !commit_i) |=> ($stable(len_o) && $stable(ratio_o)));

endmodule

// File: rtl/pwin_range.sv
module pwin_range #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SEG_SHIFT = 5,
  parameter int unsigned IDX_W     = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] len_i,
  output logic              in_win_o,
  output logic [IDX_W-1:0]  seg_idx_o
);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] seg_full;

  // Compare the offset against the length, so base + len can never overflow.
  always_comb begin
    offset   = addr_i - base_i;
    in_win_o = (addr_i >= base_i) && (offset < len_i);
    seg_full = offset >> SEG_SHIFT;
  end

  generate
    if (ADDR_W >= IDX_W) begin : g_slice
      assign seg_idx_o = seg_full[IDX_W-1:0];
    end else begin : g_extend
      assign seg_idx_o = {{(IDX_W-ADDR_W){1'b0}}, seg_full};
    end
  endgenerate

endmodule

// File: rtl/pwin_seg_hash.sv
module pwin_seg_hash
  import pwin_pkg::*;
#(
  parameter int unsigned RATIO_W = 8
) (
  input  logic [HASH_IDX_W-1:0] seg_idx_i,
  input  logic [HASH_IDX_W-1:0] seed_i,
  input  logic [RATIO_W-1:0]    ratio_i,
  output logic                  hit_o
);

  localparam logic [RATIO_W-1:0] RATIO_FULL = '1;

  logic [HASH_W-1:0] h;

  always_comb begin
    h     = pwin_hash(seg_idx_i, seed_i);
    // The all-ones ratio would leave out hash 8'hFF, so it is forced to hit.
    hit_o = (ratio_i == RATIO_FULL) || (RATIO_W'(h) < ratio_i);
  end

endmodule

// File: rtl/pwin_classifier.sv
module pwin_classifier
  import pwin_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SEG_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_len,
  input  logic [7:0]        cfg_ratio,
  input  logic [15:0]       cfg_seed,
  input  logic              cfg_commit,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_class
);

  localparam int unsigned RATIO_W = 8;
  localparam int unsigned SEED_W  = HASH_IDX_W;

  logic [ADDR_W-1:0]     base_q;
  logic [ADDR_W-1:0]     len_q;
  logic [RATIO_W-1:0]    ratio_q;
  logic [SEED_W-1:0]     seed_q;
  logic                  in_win;
  logic [HASH_IDX_W-1:0] seg_idx;
  logic                  seg_hit;
  pwin_class_e           cls_d;

  pwin_cfg_regs #(.ADDR_W(ADDR_W), .RATIO_W(RATIO_W), .SEED_W(SEED_W)) cfg_i (
    .clk(clk), .rst(rst), .commit_i(cfg_commit),
    .base_i(cfg_base), .len_i(cfg_len), .ratio_i(cfg_ratio), .seed_i(cfg_seed),
    .base_o(base_q), .len_o(len_q), .ratio_o(ratio_q), .seed_o(seed_q)
  );

  pwin_range #(.ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT), .IDX_W(HASH_IDX_W)) range_i (
    .addr_i(req_addr), .base_i(base_q), .len_i(len_q),
    .in_win_o(in_win), .seg_idx_o(seg_idx)
  );

  pwin_seg_hash #(.RATIO_W(RATIO_W)) hash_i (
    .seg_idx_i(seg_idx), .seed_i(seed_q), .ratio_i(ratio_q), .hit_o(seg_hit)
  );

  always_comb begin
    if (!in_win)      cls_d = CLS_OUT;
    else if (seg_hit) cls_d = CLS_PERSIST;
    else              cls_d = CLS_STREAM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_class <= CLS_OUT;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_class <= cls_d;
    end
  end

  a_r1_valid_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rsp_valid == $past(req_valid)));

  a_r2_legal_code: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_class));

  a_r3_outside: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !in_win) |=> (rsp_class == CLS_OUT));

  a_r6_full_ratio: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_win && ratio_q == 8'hFF) |=> (rsp_class == CLS_PERSIST));

  a_r6_zero_ratio: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_win && ratio_q == 8'h00) |=> (rsp_class == CLS_STREAM));

  a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(req_valid) && req_addr == $past(req_addr) &&
     !$past(cfg_commit) && !$past(rst)) |=> $stable(rsp_class));

endmodule

// File: tb/pwin_classifier_tb.sv
module pwin_classifier_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 32;
  localparam int SHIFT      = 6;
  localparam int WATCHDOG   = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cfg_base = '0;
  logic [AW-1:0] cfg_len = '0;
  logic [7:0]    cfg_ratio = '0;
  logic [15:0]   cfg_seed = '0;
  logic          cfg_commit = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic [1:0]    rsp_class;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwin_classifier #(.ADDR_W(AW), .SEG_SHIFT(SHIFT)) dut_i (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_len(cfg_len),
    .cfg_ratio(cfg_ratio), .cfg_seed(cfg_seed), .cfg_commit(cfg_commit),
    .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_class(rsp_class)
  );

  typedef struct packed {
    logic          do_cfg;
    logic [AW-1:0] base;
    logic [AW-1:0] len;
    logic [7:0]    ratio;
    logic [AW-1:0] addr;
    logic [1:0]    exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_1000, 32'h0000_0400, 8'hFF, 32'h0000_1000, 2'b01}, // R6 first byte
    '{1'b0, 32'h0,         32'h0,         8'h00, 32'h0000_13FF, 2'b01}, // R3 last byte
    '{1'b0, 32'h0,         32'h0,         8'h00, 32'h0000_1400, 2'b00}, // R3 end excluded
    '{1'b0, 32'h0,         32'h0,         8'h00, 32'h0000_0FFF, 2'b00}, // R3 below base
    '{1'b1, 32'h0000_1000, 32'h0000_0400, 8'h00, 32'h0000_1000, 2'b10}, // R6 zero ratio
    '{1'b0, 32'h0,         32'h0,         8'h00, 32'h0000_13C0, 2'b10}, // R6 last segment
    '{1'b0, 32'h0,         32'h0,         8'h00, 32'hFFFF_FFFF, 2'b00}, // R3 far above
    '{1'b1, 32'hFFFF_FF00, 32'h0000_0100, 8'hFF, 32'hFFFF_FFFF, 2'b01}, // R3 top of space
    '{1'b0, 32'h0,         32'h0,         8'h00, 32'h0000_0000, 2'b00}, // R3 no wrap
    '{1'b1, 32'hFFFF_FF00, 32'h0000_0000, 8'hFF, 32'hFFFF_FF00, 2'b00}  // R3 empty window
  };

  function automatic logic [7:0] model_hash(input logic [15:0] idx, input logic [15:0] seed);
    logic [15:0] x;
    logic [15:0] y;
    logic [15:0] z;
    x = idx ^ seed;
    y = x ^ (x >> 7);
    z = y * 16'h2F5B;
    return z[15:8];
  endfunction

  function automatic logic [1:0] model_class(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                             input logic [AW-1:0] l, input logic [7:0] r,
                                             input logic [15:0] s);
    logic [AW-1:0] off;
    logic [AW-1:0] seg;
    off = a - b;
    if (a < b || off >= l) return 2'b00;
    seg = off >> SHIFT;
    if (r == 8'hFF || model_hash(seg[15:0], s) < r) return 2'b01;
    return 2'b10;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic configure(input logic [AW-1:0] b, input logic [AW-1:0] l,
                           input logic [7:0] r, input logic [15:0] s);
    @(negedge clk);
    cfg_base = b; cfg_len = l; cfg_ratio = r; cfg_seed = s; cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
  endtask

  // Drive at a falling edge; the response is registered at the next rising edge
  // and sampled at the falling edge after it.
  task automatic probe(input logic [AW-1:0] a, output logic [1:0] got);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    got = rsp_class;
    check(rsp_valid === 1'b1, "R1 response valid", 32'(rsp_valid), 32'h1);
    check(rsp_class !== 2'b11, "R2 legal code", 32'(rsp_class), 32'h0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual %0d expected fewer cycles", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] got;
    logic [1:0] first;
    logic [AW-1:0] a;
    int hits;
    int mhits;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rsp_valid === 1'b0, "R9 reset valid", 32'(rsp_valid), 32'h0);
    check(rsp_class === 2'b00, "R9 reset class", 32'(rsp_class), 32'h0);
    rst = 1'b0;

    // R9: zero length after reset puts everything outside
    probe(32'h0000_0000, got);
    check(got === 2'b00, "R9 default window empty", 32'(got), 32'h0);

    // R1: valid drops one cycle after the request does
    @(negedge clk);
    check(rsp_valid === 1'b0, "R1 valid follows idle", 32'(rsp_valid), 32'h0);

    // Table of vectors
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].do_cfg) configure(VECS[i].base, VECS[i].len, VECS[i].ratio, 16'h1234);
      probe(VECS[i].addr, got);
      check(got === VECS[i].exp, $sformatf("R3/R6 table[%0d]", i), 32'(got), 32'(VECS[i].exp));
    end

    // R5 and R4: sweep 64 segments with a middling ratio, first and last byte
    configure(32'h0000_2000, 32'h0000_1000, 8'd100, 16'hA5C3);
    hits = 0; mhits = 0;
    for (int s = 0; s < 64; s++) begin
      logic [1:0] e;
      a = 32'h0000_2000 + 32'(s) * 32'd64;
      e = model_class(a, 32'h0000_2000, 32'h0000_1000, 8'd100, 16'hA5C3);
      probe(a, got);
      check(got === e, $sformatf("R5 segment %0d", s), 32'(got), 32'(e));
      if (got == 2'b01) hits++;
      if (e == 2'b01) mhits++;
      first = got;
      probe(a + 32'd63, got);
      check(got === first, $sformatf("R4 segment %0d last byte", s), 32'(got), 32'(first));
    end
    check(hits == mhits, "R5 persisting count", 32'(hits), 32'(mhits));

    // R5: a different seed, sampled segments
    configure(32'h0000_2000, 32'h0000_1000, 8'd180, 16'h0F0F);
    for (int s = 0; s < 64; s += 5) begin
      logic [1:0] e;
      a = 32'h0000_2000 + 32'(s) * 32'd64 + 32'd17;
      e = model_class(a, 32'h0000_2000, 32'h0000_1000, 8'd180, 16'h0F0F);
      probe(a, got);
      check(got === e, $sformatf("R5 reseeded segment %0d", s), 32'(got), 32'(e));
    end

    // R8: repeated requests to one address, back to back
    a = 32'h0000_2A40;
    first = model_class(a, 32'h0000_2000, 32'h0000_1000, 8'd180, 16'h0F0F);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(rsp_class === first, $sformatf("R8 repeat %0d", k), 32'(rsp_class), 32'(first));
    end
    req_valid = 1'b0;

    // R7: request in the commit cycle sees the old configuration
    configure(32'h0000_3000, 32'h0000_0100, 8'hFF, 16'h0000);
    @(negedge clk);
    cfg_base = 32'h0000_3000; cfg_len = 32'h0000_0100; cfg_ratio = 8'h00; cfg_seed = 16'h5555;
    cfg_commit = 1'b1; req_valid = 1'b1; req_addr = 32'h0000_3040;
    @(negedge clk);
    check(rsp_class === 2'b01, "R7 commit cycle uses old config", 32'(rsp_class), 32'h1);
    cfg_commit = 1'b0;
    @(negedge clk);
    check(rsp_class === 2'b10, "R7 next cycle uses new config", 32'(rsp_class), 32'h2);
    req_valid = 1'b0;

    // R7: all fields move together, the window shrinks to one segment
    configure(32'h0000_3000, 32'h0000_0040, 8'hFF, 16'h0000);
    probe(32'h0000_3040, got);
    check(got === 2'b00, "R7 new length applied", 32'(got), 32'h0);
    probe(32'h0000_303F, got);
    check(got === 2'b01, "R7 new ratio applied", 32'(got), 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule